// File: doc/BRIEF.md
# Time-Distributed Majority Vote Accumulator

Three redundant processing elements work through their own input streams, so the results they produce for one input pattern can turn up on different cycles. This block lines those results up by input symbol. A commonality event opens a vote. It stores the shared symbol and the result of the element that produced the match. The two missing results are taken later, when their elements report a result tagged with the same symbol. Once all three slots are full, the block compares the three words and issues the voted word.

Each vote also updates one long-lived agreement counter per element. Over many votes, the healthy elements pull ahead of the faulty ones, even when two elements are faulty and a single vote could not tell them apart. Only one symbol is pending at a time. Commonality events that arrive while a vote is open are dropped.

Top module: `tdv_vote_accum`

## Requirements
- R1: After reset, `busy`, `vote_done` and `vote_indet` are 0 and every weight counter is 0.
- R2: When `busy` is 0, a `hit_valid` pulse with `hit_pe` in 0..2 opens a vote. It stores `hit_sym` and puts `hit_result` into the slot of element `hit_pe`, and `busy` reads 1 on the next cycle. A pulse with `hit_pe` = 3 is ignored and `busy` stays 0.
- R3: While a vote is open, element i's result is stored only if `res_valid[i]` is 1, its tag `res_sym[i*SYM_W +: SYM_W]` equals the stored symbol, and slot i is still empty. Results with another tag, and repeat results for a slot that is already full, have no effect.
- R4: A `hit_valid` pulse while `busy` is 1 is ignored and does not change the stored symbol.
- R5: No vote is issued until all three slots are full. `vote_done` is high for exactly one cycle, namely the cycle after the third result is stored, and `vote_word` is valid during that cycle.
- R6: If at least two of the three stored words are equal, `vote_word` is that word and `vote_indet` is 0.
- R7: If all three stored words differ, `vote_indet` is 1 together with `vote_done` for that one cycle, `vote_word` is 0, and no weight changes.
- R8: On a vote that has a majority, weight i (`weight[i*WGT_W +: WGT_W]`) goes up by one for every element whose word equals the voted word. It holds at 2^WGT_W-1 instead of wrapping. Weights change in no other case.
- R9: In the `vote_done` cycle `busy` is already 0 and all slots are empty, so a new vote can open at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | Commonality event strobe |
| hit_sym | input | SYM_W | Shared input symbol of the event |
| hit_pe | input | 2 | Element that produced the matching result (0..2) |
| hit_result | input | RES_W | That element's result word |
| res_valid | input | 3 | Per-element result strobe |
| res_sym | input | 3*SYM_W | Per-element symbol tags, element i at bits i*SYM_W |
| res_data | input | 3*RES_W | Per-element result words, element i at bits i*RES_W |
| busy | output | 1 | A vote is open and waiting for results |
| vote_done | output | 1 | One-cycle vote-issued strobe |
| vote_indet | output | 1 | One-cycle flag: the vote had no majority |
| vote_word | output | RES_W | Voted word (0 when indeterminate) |
| weight | output | 3*WGT_W | Per-element agreement counters, element i at bits i*WGT_W |

## Verification
The bench sends stray traffic while a vote is open. This traffic is a second commonality event, results with the wrong symbol on all three lanes, and a repeat result with different data for the slot that is already full. A design that let any of it through would issue the vote early or with a corrupted word. The bench checks the cycle of `vote_done` in both arrival orders: two results on one cycle, and results spread over cycles. An off-by-one in the completeness check shows up as an early or late strobe. Votes where all three words differ check that no weight moves and that the word is cleared. A long run of unanimous votes drives every counter to its ceiling, so a counter that wraps would fall back to a small value.

// File: rtl/tdv_pkg.sv
package tdv_pkg;
   localparam int unsigned PE_COUNT = 3;
   localparam int unsigned PE_IDX_W = 2;

   typedef enum logic [0:0] {
      ACC_IDLE    = 1'b0,
      ACC_COLLECT = 1'b1
   } acc_state_e;
endpackage

// File: rtl/tdv_slot_bank.sv
module tdv_slot_bank
   import tdv_pkg::*;
#(
   parameter int unsigned RES_W = 32,
   parameter int unsigned SYM_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_en,
   input  logic [PE_IDX_W-1:0]         load_pe,
   input  logic [RES_W-1:0]            load_data,
   input  logic [SYM_W-1:0]            cur_sym,
   input  logic                        collect_en,
   input  logic                        clear_en,
   input  logic [PE_COUNT-1:0]         res_valid,
   input  logic [PE_COUNT*SYM_W-1:0]   res_sym,
   input  logic [PE_COUNT*RES_W-1:0]   res_data,
   output logic [PE_COUNT-1:0]         filled,
   output logic [PE_COUNT*RES_W-1:0]   slot_data
);

   generate
      for (genvar g = 0; g < PE_COUNT; g++) begin : g_slot
         logic             full_q;
         logic [RES_W-1:0] data_q;
         logic             tag_match;
         logic             take_res;
         logic             take_hit;

         assign tag_match = (res_sym[g*SYM_W +: SYM_W] == cur_sym);
         assign take_res  = collect_en && res_valid[g] && tag_match && !full_q;
         assign take_hit  = load_en && (load_pe == PE_IDX_W'(g));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               full_q <= 1'b0;
               data_q <= '0;
            end else if (clear_en) begin
               full_q <= 1'b0;
            end else if (take_hit) begin
               full_q <= 1'b1;
               data_q <= load_data;
            end else if (take_res) begin
               full_q <= 1'b1;
               data_q <= res_data[g*RES_W +: RES_W];
            end
         end

         assign filled[g]                  = full_q;
         assign slot_data[g*RES_W +: RES_W] = data_q;
      end
   endgenerate

endmodule

// File: rtl/tdv_majority.sv
module tdv_majority
   import tdv_pkg::*;
#(
   parameter int unsigned RES_W = 32
) (
   input  logic [PE_COUNT*RES_W-1:0] slot_data,
   output logic [RES_W-1:0]          maj_word,
   output logic                      maj_found,
   output logic [PE_COUNT-1:0]       agree
);

   logic [RES_W-1:0] w0, w1, w2;
   logic             eq01, eq02, eq12;

   assign w0   = slot_data[0*RES_W +: RES_W];
   assign w1   = slot_data[1*RES_W +: RES_W];
   assign w2   = slot_data[2*RES_W +: RES_W];
   assign eq01 = (w0 == w1);
   assign eq02 = (w0 == w2);
   assign eq12 = (w1 == w2);

   always_comb begin
      maj_found = 1'b1;
      maj_word  = w0;
      if (eq01 || eq02) begin
         maj_word = w0;
      end else if (eq12) begin
         maj_word = w1;
      end else begin
         maj_found = 1'b0;
         maj_word  = '0;
      end
   end

   generate
      for (genvar g = 0; g < PE_COUNT; g++) begin : g_agree
         assign agree[g] = maj_found && (slot_data[g*RES_W +: RES_W] == maj_word);
      end
   endgenerate

endmodule

// File: rtl/tdv_weight_bank.sv
module tdv_weight_bank
   import tdv_pkg::*;
#(
   parameter int unsigned WGT_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      upd_en,
   input  logic [PE_COUNT-1:0]       agree,
   output logic [PE_COUNT*WGT_W-1:0] weight
);

   localparam logic [WGT_W-1:0] W_MAX = '1;

   generate
      for (genvar g = 0; g < PE_COUNT; g++) begin : g_wgt
         logic [WGT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (upd_en && agree[g] && (cnt_q != W_MAX)) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign weight[g*WGT_W +: WGT_W] = cnt_q;
      end
   endgenerate

endmodule

// File: rtl/tdv_vote_accum.sv
module tdv_vote_accum
   import tdv_pkg::*;
#(
   parameter int unsigned RES_W = 32,
   parameter int unsigned SYM_W = 16,
   parameter int unsigned WGT_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      hit_valid,
   input  logic [SYM_W-1:0]          hit_sym,
   input  logic [PE_IDX_W-1:0]       hit_pe,
   input  logic [RES_W-1:0]          hit_result,
   input  logic [PE_COUNT-1:0]       res_valid,
   input  logic [PE_COUNT*SYM_W-1:0] res_sym,
   input  logic [PE_COUNT*RES_W-1:0] res_data,
   output logic                      busy,
   output logic                      vote_done,
   output logic                      vote_indet,
   output logic [RES_W-1:0]          vote_word,
   output logic [PE_COUNT*WGT_W-1:0] weight
);

   generate
      if (RES_W < 1) begin : g_bad_res_w
         $error("tdv_vote_accum: RES_W must be at least 1");
      end
      if (SYM_W < 1) begin : g_bad_sym_w
         $error("tdv_vote_accum: SYM_W must be at least 1");
      end
      if (WGT_W < 1 || WGT_W > 32) begin : g_bad_wgt_w
         $error("tdv_vote_accum: WGT_W must lie in 1..32");
      end
   endgenerate

   acc_state_e               state_q;
   logic [SYM_W-1:0]         sym_q;
   logic                     done_q;
   logic                     indet_q;
   logic [RES_W-1:0]         word_q;

   logic                     hit_take;
   logic                     all_full;
   logic                     vote_fire;
   logic [PE_COUNT-1:0]      filled;
   logic [PE_COUNT*RES_W-1:0] slot_data;
   logic [RES_W-1:0]         maj_word;
   logic                     maj_found;
   logic [PE_COUNT-1:0]      agree;

   assign hit_take  = (state_q == ACC_IDLE) && hit_valid &&
                      (hit_pe < PE_IDX_W'(PE_COUNT));
   assign all_full  = &filled;
   assign vote_fire = (state_q == ACC_COLLECT) && all_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ACC_IDLE;
         sym_q   <= '0;
         done_q  <= 1'b0;
         indet_q <= 1'b0;
         word_q  <= '0;
      end else begin
         done_q  <= vote_fire;
         indet_q <= vote_fire && !maj_found;
         if (hit_take) begin
            state_q <= ACC_COLLECT;
            sym_q   <= hit_sym;
         end else if (vote_fire) begin
            state_q <= ACC_IDLE;
         end
         if (vote_fire) begin
            word_q <= maj_word;
         end
      end
   end

   tdv_slot_bank #(
      .RES_W (RES_W),
      .SYM_W (SYM_W)
   ) u_slots (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_en    (hit_take),
      .load_pe    (hit_pe),
      .load_data  (hit_result),
      .cur_sym    (sym_q),
      .collect_en (state_q == ACC_COLLECT),
      .clear_en   (vote_fire),
      .res_valid  (res_valid),
      .res_sym    (res_sym),
      .res_data   (res_data),
      .filled     (filled),
      .slot_data  (slot_data)
   );

   tdv_majority #(
      .RES_W (RES_W)
   ) u_vote (
      .slot_data (slot_data),
      .maj_word  (maj_word),
      .maj_found (maj_found),
      .agree     (agree)
   );

   tdv_weight_bank #(
      .WGT_W (WGT_W)
   ) u_wgt (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_en (vote_fire && maj_found),
      .agree  (agree),
      .weight (weight)
   );

   assign busy       = (state_q == ACC_COLLECT);
   assign vote_done  = done_q;
   assign vote_indet = indet_q;
   assign vote_word  = word_q;

endmodule

// File: rtl/tdv_vote_accum_chk.sv
module tdv_vote_accum_chk
   import tdv_pkg::*;
#(
   parameter int unsigned WGT_W = 16
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      hit_valid,
   input logic                      busy,
   input logic                      vote_done,
   input logic                      vote_indet,
   input logic [PE_COUNT*WGT_W-1:0] weight
);

   localparam logic [WGT_W-1:0] W_MAX = '1;

   // R2: a vote only opens in response to a commonality event
   assert_open_on_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(hit_valid));

   // R5: the vote strobe lasts a single cycle
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vote_done |=> !vote_done);

   // R7: the no-majority flag only appears with the vote strobe
   assert_indet_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      vote_indet |-> vote_done);

   // R8: weights move only on a vote that had a majority
   assert_weight_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!vote_done || vote_indet) |-> $stable(weight));

   // R9: the accumulator is free again when the vote is issued
   assert_idle_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      vote_done |-> !busy);

   generate
      for (genvar g = 0; g < PE_COUNT; g++) begin : g_sat
         // R8: a counter at its ceiling stays there
         assert_weight_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (weight[g*WGT_W +: WGT_W] == W_MAX) |=> (weight[g*WGT_W +: WGT_W] == W_MAX));
      end
   endgenerate

endmodule

bind tdv_vote_accum tdv_vote_accum_chk #(
   .WGT_W (WGT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hit_valid  (hit_valid),
   .busy       (busy),
   .vote_done  (vote_done),
   .vote_indet (vote_indet),
   .weight     (weight)
);

// File: tb/tdv_vote_accum_tb_top.sv
module tdv_vote_accum_tb_top;
   localparam int RES_W = 32;
   localparam int SYM_W = 8;
   localparam int WGT_W = 3;
   localparam int WMAX  = (1 << WGT_W) - 1;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 hit_valid = 1'b0;
   logic [SYM_W-1:0]     hit_sym = '0;
   logic [1:0]           hit_pe = '0;
   logic [RES_W-1:0]     hit_result = '0;
   logic [2:0]           res_valid = '0;
   logic [3*SYM_W-1:0]   res_sym = '0;
   logic [3*RES_W-1:0]   res_data = '0;
   logic                 busy;
   logic                 vote_done;
   logic                 vote_indet;
   logic [RES_W-1:0]     vote_word;
   logic [3*WGT_W-1:0]   weight;

   always #2.5 clk = ~clk;

   tdv_vote_accum #(.RES_W(RES_W), .SYM_W(SYM_W), .WGT_W(WGT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_sym(hit_sym),
      .hit_pe(hit_pe), .hit_result(hit_result), .res_valid(res_valid),
      .res_sym(res_sym), .res_data(res_data), .busy(busy),
      .vote_done(vote_done), .vote_indet(vote_indet), .vote_word(vote_word),
      .weight(weight));

   typedef struct {
      logic [RES_W-1:0] word;
      logic             indet;
      int               w [3];
   } exp_t;

   exp_t exp_q[$];
   int   exp_w [3] = '{0, 0, 0};
   int   n_chk = 0;
   int   n_fail = 0;
   bit   finished = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && vote_done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R5", "unexpected vote", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(vote_word == e.word, "R6", "voted word", vote_word, e.word);
            check(vote_indet == e.indet, "R7", "indeterminate flag", vote_indet, e.indet);
            for (int k = 0; k < 3; k++)
               check(int'(weight[k*WGT_W +: WGT_W]) == e.w[k], "R8", "weight",
                     weight[k*WGT_W +: WGT_W], e.w[k]);
         end
      end
   end

   task automatic run_vote(input logic [SYM_W-1:0] sym, input int first,
                           input logic [RES_W-1:0] r0, input logic [RES_W-1:0] r1,
                           input logic [RES_W-1:0] r2, input bit together, input bit noise);
      logic [RES_W-1:0] rv [3];
      exp_t e;
      int o1, o2;
      rv[0] = r0; rv[1] = r1; rv[2] = r2;
      if (r0 == r1 || r0 == r2) begin e.word = r0; e.indet = 0; end
      else if (r1 == r2)        begin e.word = r1; e.indet = 0; end
      else                      begin e.word = '0; e.indet = 1; end
      for (int k = 0; k < 3; k++) begin
         if (!e.indet && rv[k] == e.word && exp_w[k] < WMAX) exp_w[k]++;
         e.w[k] = exp_w[k];
      end
      exp_q.push_back(e);
      o1 = (first + 1) % 3;
      o2 = (first + 2) % 3;

      @(negedge clk);
      hit_valid = 1; hit_sym = sym; hit_pe = first[1:0]; hit_result = rv[first];
      @(negedge clk);
      hit_valid = 0;
      check(busy == 1, "R2", "busy after hit", busy, 1);
      if (noise) begin
         hit_valid = 1; hit_sym = sym + 1; hit_pe = o1[1:0]; hit_result = ~rv[o1];
         res_valid = 3'b111;
         for (int k = 0; k < 3; k++) begin
            res_sym[k*SYM_W +: SYM_W]  = sym ^ 8'h5A;
            res_data[k*RES_W +: RES_W] = 32'hBAD0_0000 | k;
         end
         @(negedge clk);
         hit_valid = 0;
         res_valid = '0;
         res_valid[first] = 1'b1;
         res_sym[first*SYM_W +: SYM_W]  = sym;
         res_data[first*RES_W +: RES_W] = ~rv[first];
         @(negedge clk);
         res_valid = '0;
         check(busy == 1, "R4", "busy kept after stray hit", busy, 1);
         check(vote_done == 0, "R3", "no vote from stray results", vote_done, 0);
      end
      res_sym[o1*SYM_W +: SYM_W]  = sym;
      res_data[o1*RES_W +: RES_W] = rv[o1];
      res_sym[o2*SYM_W +: SYM_W]  = sym;
      res_data[o2*RES_W +: RES_W] = rv[o2];
      res_valid = '0;
      res_valid[o1] = 1'b1;
      if (together) begin
         res_valid[o2] = 1'b1;
         @(negedge clk);
      end else begin
         @(negedge clk);
         check(vote_done == 0, "R5", "no vote with two slots", vote_done, 0);
         res_valid = '0;
         res_valid[o2] = 1'b1;
         @(negedge clk);
      end
      res_valid = '0;
      check(vote_done == 0, "R5", "vote not yet issued", vote_done, 0);
      @(negedge clk);
      check(vote_done == 1, "R5", "vote one cycle after third result", vote_done, 1);
      check(busy == 0, "R9", "idle at vote", busy, 0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(busy == 0, "R1", "busy at reset", busy, 0);
      check(vote_done == 0, "R1", "vote_done at reset", vote_done, 0);
      check(vote_indet == 0, "R1", "vote_indet at reset", vote_indet, 0);
      check(weight == '0, "R1", "weights at reset", weight, 0);

      // R2: element index 3 does not open a vote
      hit_valid = 1; hit_sym = 8'h33; hit_pe = 2'd3; hit_result = 32'h1;
      @(negedge clk);
      hit_valid = 0;
      check(busy == 0, "R2", "hit with element 3 ignored", busy, 0);

      run_vote(8'h10, 0, 32'h8887_7778, 32'h8887_7778, 32'h8887_7778, 0, 0);
      run_vote(8'h11, 1, 32'h8877_7777, 32'h8887_7778, 32'h8887_7778, 1, 0);
      run_vote(8'h12, 2, 32'h0000_1234, 32'h0000_1234, 32'hFFFF_0000, 0, 0);
      run_vote(8'h13, 0, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 0, 0); // R7
      run_vote(8'h14, 2, 32'hCAFE_0001, 32'hCAFE_0002, 32'hCAFE_0001, 0, 1); // R3 R4
      run_vote(8'h15, 0, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1, 1);
      run_vote(8'h16, 1, 32'hA, 32'hB, 32'hC, 1, 0);                         // R7
      for (int v = 0; v < 10; v++)
         run_vote(8'h40 + v[7:0], v % 3, 32'h5555_0000 + v, 32'h5555_0000 + v,
                  32'h5555_0000 + v, v[0], 0);
      @(negedge clk);
      for (int k = 0; k < 3; k++)
         check(int'(weight[k*WGT_W +: WGT_W]) == WMAX, "R8", "saturated weight",
               weight[k*WGT_W +: WGT_W], WMAX);
      check(exp_q.size() == 0, "R5", "all expected votes seen", exp_q.size(), 0);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule